// File: doc/BRIEF.md
# Dual Down-Counting Timer

This block holds two independent down-counting timers behind one word-addressed register window. The window is driven by single-cycle write and read strobes. Software sets a reload value and picks a mode for each timer, either periodic or one-shot. The counter then counts down by one on every clock while it is enabled.

When the counter reaches zero it raises a sticky status bit, which software clears by writing 1 to it. If interrupts are enabled for that timer, its interrupt line follows the status bit.

Each timer has two ways to take a new reload value:

- An immediate load restarts the count at once.
- A background load replaces the reload value without disturbing the running count, so the new period begins at the next reload.

A separate masked status view shows the raw bit gated by the interrupt enable. Reads are combinational, so `rdata` is valid in the same cycle as `rd_en`. It reads as zero when `rd_en` is low.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register of both timers reads 0, both counters are stopped and both `irq` bits are low.
- R2: Register word offset is `addr >> 2`. Timer k uses word offsets 6k to 6k+5, laid out as follows:
  - +0: count
  - +1: load
  - +2: background load
  - +3: control
  - +4: raw status
  - +5: masked status

  Reads at word offsets 12 and above return 0, and writes there change nothing.
- R3: Control bit 0 is enable, bit 1 is one-shot (0 selects periodic) and bit 2 is interrupt enable. A control write with bit 0 set copies the load register into the counter. A control write with bit 0 clear freezes the counter at its present value.
- R4: While enabled, the counter drops by one per clock. On a clock where it is enabled and already at 0, raw status bit 0 is set. In periodic mode the counter also reloads from the load register, which gives a period of load+1 clocks.
- R5: A write to the load register while the timer is enabled puts the new value into the counter at once. That clock does not count as an expiry.
- R6: A write to the background load register sets both the background and the load registers. The running count keeps decrementing, and the new value is used at the next reload.
- R7: In one-shot mode, expiry leaves the counter at 0 and enabled, and raw status is set only once. It is set again only after a load write or an enabling control write re-arms the timer.
- R8: Writing 1 to raw status bit 0 clears it, and writing 0 leaves it unchanged. If an expiry happens in the same clock as the clear, the bit stays set.
- R9: Masked status bit 0 and `irq[k]` both equal raw status bit 0 AND control bit 2.
- R10: Writes to the count and masked status offsets are ignored. The counter keeps its normal behaviour.
- R11: Activity on one timer never changes the count, status or interrupt of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| rd_en | input | 1 | Read strobe, gates `rdata` |
| addr | input | AW | Byte address, bits [1:0] ignored |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| irq | output | NT | One interrupt line per timer |

## Verification
The bench builds the block with its default parameters:

- `DW = 32` and `NT = 2` give the two-timer window of twelve words.
- `AW = 8` leaves offsets 12 to 63 unused, so the bench can probe the out-of-range read and write path.

With small load values (1 to 9), each expiry, periodic reload, one-shot hold and priority case is reached in a handful of cycles. Both timers run in the same sequence, which shows that they do not disturb each other.

// File: rtl/dual_down_timer.sv
module dual_down_timer #(
  parameter int DW = 32,
  parameter int NT = 2,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NT-1:0] irq
);
  localparam int REGS = 6;
  localparam int WW   = AW - 2;

  logic [WW-1:0] word;
  logic [1:0]    unused_lsb;
  assign word       = addr[AW-1:2];
  assign unused_lsb = addr[1:0];

  logic [DW-1:0] cnt  [NT];
  logic [DW-1:0] ld   [NT];
  logic [DW-1:0] bg   [NT];
  logic [2:0]    ctl  [NT];
  logic          ris  [NT];
  logic          spent[NT];
  logic [DW-1:0] rv   [NT];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam logic [WW-1:0] B_VAL = WW'(REGS*i + 0);
    localparam logic [WW-1:0] B_LD  = WW'(REGS*i + 1);
    localparam logic [WW-1:0] B_BG  = WW'(REGS*i + 2);
    localparam logic [WW-1:0] B_CTL = WW'(REGS*i + 3);
    localparam logic [WW-1:0] B_RIS = WW'(REGS*i + 4);
    localparam logic [WW-1:0] B_MIS = WW'(REGS*i + 5);

    logic w_ld, w_bg, w_ctl, w_ris;
    assign w_ld  = wr_en && word == B_LD;
    assign w_bg  = wr_en && word == B_BG;
    assign w_ctl = wr_en && word == B_CTL;
    assign w_ris = wr_en && word == B_RIS;

    assign irq[i] = ris[i] & ctl[i][2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[i]   <= '0;
        ld[i]    <= '0;
        bg[i]    <= '0;
        ctl[i]   <= '0;
        ris[i]   <= 1'b0;
        spent[i] <= 1'b0;
      end else begin
        if (w_ris && wdata[0]) ris[i] <= 1'b0;
        if (w_ctl) begin
          ctl[i] <= wdata[2:0];
          if (wdata[0]) begin
            cnt[i]   <= ld[i];
            spent[i] <= 1'b0;
          end
        end else if (w_ld) begin
          ld[i] <= wdata;
          if (ctl[i][0]) begin
            cnt[i]   <= wdata;
            spent[i] <= 1'b0;
          end
        end else begin
          if (w_bg) begin
            bg[i] <= wdata;
            ld[i] <= wdata;
          end
          if (ctl[i][0]) begin
            if (cnt[i] == '0) begin
              if (!spent[i]) ris[i] <= 1'b1;
              if (!ctl[i][1]) cnt[i] <= ld[i];
              else            spent[i] <= 1'b1;
            end else begin
              cnt[i] <= cnt[i] - 1'b1;
            end
          end
        end
      end
    end

    always_comb begin
      rv[i] = '0;
      if (rd_en) begin
        case (word)
          B_VAL:   rv[i] = cnt[i];
          B_LD:    rv[i] = ld[i];
          B_BG:    rv[i] = bg[i];
          B_CTL:   rv[i] = DW'(ctl[i]);
          B_RIS:   rv[i] = DW'(ris[i]);
          B_MIS:   rv[i] = DW'(irq[i]);
          default: rv[i] = '0;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NT; i++) rdata = rdata | rv[i];
  end
endmodule

// File: rtl/dual_down_timer_chk.sv
module dual_down_timer_chk #(
  parameter int DW = 32,
  parameter int NT = 2,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-3:0] word,
  input logic [2:0]    wd,
  input logic [NT-1:0] irq,
  input logic [DW-1:0] cnt0,
  input logic          en0,
  input logic          ris0
);
  // R1
  reset_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> irq == '0);

  // R9
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == (AW-2)'(3) && !wd[2]) |=> !irq[0]);

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en0 && !wr_en) |=> $stable(cnt0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 && !wr_en && cnt0 != '0) |=> cnt0 == $past(cnt0) - 1'b1);

  // R8
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == (AW-2)'(4) && wd[0] && !en0) |=> !ris0);
endmodule

bind dual_down_timer dual_down_timer_chk #(.DW(DW), .NT(NT), .AW(AW)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .wr_en(wr_en),
  .word (addr[AW-1:2]),
  .wd   (wdata[2:0]),
  .irq  (irq),
  .cnt0 (cnt[0]),
  .en0  (ctl[0][0]),
  .ris0 (ris[0])
);

// File: tb/test_dual_down_timer.sv
module test_dual_down_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dual_down_timer i_dual_down_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // op: 0 write, 1 read and compare, 2 compare irq
  localparam int NV = 50;
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 4'd3, 8'h04, 32'd3},   // R3 load t0 = 3
    {2'd0, 4'd3, 8'h0C, 32'd5},   // R3 enable periodic, irq on
    {2'd1, 4'd3, 8'h00, 32'd3},
    {2'd1, 4'd4, 8'h00, 32'd2},   // R4 decrement
    {2'd1, 4'd2, 8'h04, 32'd3},   // R2 load offset
    {2'd1, 4'd4, 8'h10, 32'd0},
    {2'd2, 4'd9, 8'h00, 32'd1},   // R9 irq after expiry
    {2'd1, 4'd9, 8'h14, 32'd1},
    {2'd0, 4'd3, 8'h0C, 32'd4},   // R3 stop
    {2'd1, 4'd3, 8'h00, 32'd1},
    {2'd0, 4'd8, 8'h10, 32'd0},   // R8 write 0
    {2'd1, 4'd8, 8'h10, 32'd1},
    {2'd0, 4'd8, 8'h10, 32'd1},   // R8 clear
    {2'd1, 4'd8, 8'h10, 32'd0},
    {2'd2, 4'd8, 8'h00, 32'd0},
    {2'd0, 4'd6, 8'h04, 32'd2},   // R6 setup
    {2'd0, 4'd6, 8'h0C, 32'd1},
    {2'd0, 4'd6, 8'h08, 32'd5},   // R6 background write
    {2'd1, 4'd6, 8'h00, 32'd1},
    {2'd1, 4'd6, 8'h04, 32'd5},
    {2'd1, 4'd6, 8'h00, 32'd5},   // R6 new period at reload
    {2'd1, 4'd4, 8'h10, 32'd1},
    {2'd1, 4'd9, 8'h14, 32'd0},   // R9 mask off
    {2'd2, 4'd9, 8'h00, 32'd0},
    {2'd1, 4'd6, 8'h08, 32'd5},
    {2'd0, 4'd5, 8'h04, 32'd9},   // R5 immediate load
    {2'd1, 4'd5, 8'h00, 32'd9},
    {2'd0, 4'd10, 8'h00, 32'd77}, // R10 count write ignored
    {2'd1, 4'd10, 8'h00, 32'd7},
    {2'd0, 4'd3, 8'h0C, 32'd0},
    {2'd0, 4'd8, 8'h10, 32'd1},
    {2'd0, 4'd7, 8'h1C, 32'd1},   // R7 t1 load 1
    {2'd0, 4'd7, 8'h24, 32'd7},   // R7 one-shot, irq on
    {2'd1, 4'd7, 8'h18, 32'd1},
    {2'd1, 4'd7, 8'h18, 32'd0},
    {2'd1, 4'd7, 8'h18, 32'd0},   // R7 holds 0
    {2'd2, 4'd9, 8'h00, 32'd2},
    {2'd1, 4'd9, 8'h2C, 32'd1},
    {2'd0, 4'd8, 8'h28, 32'd1},
    {2'd1, 4'd7, 8'h28, 32'd0},   // R7 no refire
    {2'd1, 4'd7, 8'h28, 32'd0},
    {2'd2, 4'd7, 8'h00, 32'd0},
    {2'd1, 4'd11, 8'h00, 32'd6},  // R11 t0 untouched
    {2'd0, 4'd2, 8'h30, 32'hFF},  // R2 out of range
    {2'd1, 4'd2, 8'h30, 32'd0},
    {2'd1, 4'd11, 8'h10, 32'd0},
    {2'd0, 4'd7, 8'h1C, 32'd0},   // R7 rearm by load
    {2'd1, 4'd7, 8'h18, 32'd0},
    {2'd1, 4'd7, 8'h28, 32'd1},
    {2'd2, 4'd11, 8'h00, 32'd2}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input int req, input logic [7:0] a,
                      input logic [31:0] d);
    addr  = a;
    wdata = d;
    wr_en = (op == 2'd0);
    rd_en = (op == 2'd1);
    #1;
    if (op == 2'd1) chk(req, rdata, d);
    if (op == 2'd2) chk(req, {30'd0, irq}, d);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of all twelve words
    for (int w = 0; w < 12; w++) step(2'd1, 1, 8'(w * 4), 32'd0);
    step(2'd2, 1, 8'h00, 32'd0);
    for (int k = 0; k < NV; k++)
      step(VEC[k][45:44], int'(VEC[k][43:40]), VEC[k][39:32], VEC[k][31:0]);
    // R1 reset while timer 1 is enabled and interrupting
    rst_n = 1'b0;
    rd_en = 1'b1;
    addr  = 8'h24;
    #1;
    chk(1, {30'd0, irq}, 32'd0);
    chk(1, rdata, 32'd0);
    rd_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(2'd1, 1, 8'h18, 32'd0);
    step(2'd1, 1, 8'h1C, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule